// File: doc/BRIEF.md
# Fracturable Look-Up Table with Embedded Carry

This block is a configurable 4-input look-up table realised as a binary tree of 2:1 multiplexers over a 16-bit static configuration vector. Besides the full 4-input result it brings out taps from inner tree stages. Two 3-input results come from the next-to-last stage, one over each half of the configuration. Two 2-input results come from the stage below that, and both are taken from the lower half of the configuration.

The two 2-input taps feed a hard carry stage. One tap acts as generate and the other as propagate, and a 2:1 carry multiplexer produces the carry out. A mode multiplexer sits on the carry-in path. In logic mode the cell is a plain 4-input LUT. In arithmetic mode the incoming carry takes the place of the top select input. The full output then gives the sum bit, and the cell works as one bit of a ripple adder. The carry input and carry output are hard ports: they are never part of the truth table that the tree stores. The block is purely combinational.

Top module: `frac_lut_carry`

## Requirements
- R1: With `arith_i`=0, `lut_full_o` equals `cfg_i[idx]`, where `idx` = `sel_i` read as an unsigned number (`sel_i[0]` is the LSB).
- R2: `lut_mid_o[0]` equals `cfg_i[{1'b0, sel_i[2:0]}]` and `lut_mid_o[1]` equals `cfg_i[{1'b1, sel_i[2:0]}]`, in both modes.
- R3: `lut_low_o[0]` equals `cfg_i[sel_i[1:0]]` and `lut_low_o[1]` equals `cfg_i[4 + sel_i[1:0]]`, in both modes.
- R4: When `lut_low_o[1]` (propagate) is 0, `carry_o` equals `lut_low_o[0]` (generate).
- R5: When `lut_low_o[1]` is 1, `carry_o` equals the selected carry: `carry_i` when `arith_i`=1, `sel_i[3]` when `arith_i`=0.
- R6: With `arith_i`=1, `lut_full_o` equals `cfg_i[{carry_i, sel_i[2:0]}]`, and `sel_i[3]` has no effect on any output.
- R7: With `arith_i`=0, `carry_i` has no effect on any output.
- R8: With `cfg_i`=16'h9068, `arith_i`=1, `sel_i[2]`=1, operand bits on `sel_i[0]` and `sel_i[1]`, and the carry fed bit to bit, the cell gives the sum bit on `lut_full_o` and the carry on `carry_o` of a binary ripple adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 4 | LUT data inputs; bit 0 selects at the first tree stage |
| cfg_i | input | 16 | Static truth-table configuration |
| arith_i | input | 1 | 1 = arithmetic mode, 0 = logic mode |
| carry_i | input | 1 | Carry in from the neighbouring cell |
| lut_full_o | output | 1 | Full-tree result (sum bit in arithmetic mode) |
| lut_mid_o | output | 2 | 3-input taps, lower and upper configuration halves |
| lut_low_o | output | 2 | 2-input taps over the lower configuration half (generate, propagate) |
| carry_o | output | 1 | Carry out |

## Verification
Every output is combinational, so each result is due in the same cycle as its stimulus, with zero register stages. The driver applies the inputs on a rising clock edge and queues the expected values. The monitor pops the queue and compares at the following falling edge, half a period later, so that each comparison sees settled values of exactly one stimulus. The ripple-adder pass feeds the carry of the reference sum, not the design's own carry, from one bit to the next. A wrong carry therefore shows up at its own bit and does not spread into later bits.

// File: rtl/flut_pkg.sv
package flut_pkg;
  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } flut_mode_e;

  function automatic logic mux2(input logic s, input logic d0, input logic d1);
    return s ? d1 : d0;
  endfunction
endpackage

// File: rtl/flut_mux_level.sv
// One stage of the LUT tree: halves the node count with a shared select.
module flut_mux_level #(
  parameter int N_OUT = 8
) (
  input  logic [2*N_OUT-1:0] data_i,
  input  logic               sel_i,
  output logic [N_OUT-1:0]   data_o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_node
    assign data_o[j] = flut_pkg::mux2(sel_i, data_i[2*j], data_i[2*j+1]);
  end
endmodule

// File: rtl/flut_carry.sv
// Carry-in mode mux plus hard carry mux.
module flut_carry (
  input  logic arith_i,
  input  logic carry_i,
  input  logic top_sel_i,
  input  logic gen_i,
  input  logic prop_i,
  output logic sel_o,
  output logic carry_o
);
  import flut_pkg::*;

  flut_mode_e mode;
  assign mode = flut_mode_e'(arith_i);

  always_comb begin
    unique case (mode)
      MODE_ARITH: sel_o = carry_i;
      default:    sel_o = top_sel_i;
    endcase
  end

  assign carry_o = mux2(prop_i, gen_i, sel_o);
endmodule

// File: rtl/frac_lut_carry.sv
module frac_lut_carry #(
  parameter int K = 4,
  localparam int CFG_W = 1 << K
) (
  input  logic [K-1:0]     sel_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             arith_i,
  input  logic             carry_i,
  output logic             lut_full_o,
  output logic [1:0]       lut_mid_o,
  output logic [1:0]       lut_low_o,
  output logic             carry_o
);
  logic last_sel;

  for (genvar l = 1; l <= K; l++) begin : g_lvl
    localparam int W = CFG_W >> l;
    logic [2*W-1:0] d;
    logic [W-1:0]   q;
    logic           s;
    if (l == 1) begin : g_first
      assign d = cfg_i;
    end else begin : g_inner
      assign d = g_lvl[l-1].q;
    end
    if (l == K) begin : g_top
      assign s = last_sel;
    end else begin : g_mid
      assign s = sel_i[l-1];
    end
    flut_mux_level #(.N_OUT(W)) u_lvl (
      .data_i(d),
      .sel_i (s),
      .data_o(q)
    );
  end

  // low taps: lower configuration half only
  assign lut_low_o  = g_lvl[K-2].q[1:0];
  assign lut_mid_o  = g_lvl[K-1].q;
  assign lut_full_o = g_lvl[K].q[0];

  flut_carry u_carry (
    .arith_i  (arith_i),
    .carry_i  (carry_i),
    .top_sel_i(sel_i[K-1]),
    .gen_i    (lut_low_o[0]),
    .prop_i   (lut_low_o[1]),
    .sel_o    (last_sel),
    .carry_o  (carry_o)
  );
endmodule

// File: rtl/flut_chk.sv
module flut_chk #(
  parameter int K = 4,
  localparam int CFG_W = 1 << K
) (
  input logic [K-1:0]     sel_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             arith_i,
  input logic             carry_i,
  input logic             lut_full_o,
  input logic [1:0]       lut_mid_o,
  input logic [1:0]       lut_low_o,
  input logic             carry_o
);
  localparam int HALF = CFG_W / 2;
  localparam int QTR  = CFG_W / 4;

  logic known;
  logic csel;
  assign known = !$isunknown({sel_i, cfg_i, arith_i, carry_i});
  assign csel  = arith_i ? carry_i : sel_i[K-1];

  always_comb begin
    if (known) begin
      AST_FULL_LOGIC: assert (arith_i || lut_full_o == cfg_i[sel_i]); // R1
      AST_MID_LO: assert (lut_mid_o[0] == cfg_i[{1'b0, sel_i[K-2:0]}]); // R2
      AST_MID_HI: assert (lut_mid_o[1] == cfg_i[{1'b1, sel_i[K-2:0]}]); // R2
      AST_LOW_GEN: assert (lut_low_o[0] == cfg_i[sel_i[K-3:0]]); // R3
      AST_LOW_PROP: assert (lut_low_o[1] == cfg_i[QTR + int'(sel_i[K-3:0])]); // R3
      AST_CARRY_KILL: assert (lut_low_o[1] || carry_o == lut_low_o[0]); // R4
      AST_CARRY_PASS: assert (!lut_low_o[1] || carry_o == csel); // R5
      AST_FULL_ARITH: assert (!arith_i ||
                              lut_full_o == cfg_i[int'(carry_i) * HALF + int'(sel_i[K-2:0])]); // R6
    end
  end
endmodule

bind frac_lut_carry flut_chk #(.K(K)) u_flut_chk (
  .sel_i     (sel_i),
  .cfg_i     (cfg_i),
  .arith_i   (arith_i),
  .carry_i   (carry_i),
  .lut_full_o(lut_full_o),
  .lut_mid_o (lut_mid_o),
  .lut_low_o (lut_low_o),
  .carry_o   (carry_o)
);

// File: tb/frac_lut_carry_tb_top.sv
`timescale 1ns/1ps
module frac_lut_carry_tb_top;
  localparam int WATCHDOG = 100000;

  typedef struct {
    logic       full;
    logic [1:0] mid;
    logic [1:0] low;
    logic       cout;
    string      tag_full;
    string      tag_cout;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  sel;
  logic [15:0] cfg;
  logic        arith;
  logic        cin;
  logic        full;
  logic [1:0]  mid;
  logic [1:0]  low;
  logic        cout;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  frac_lut_carry dut_i (
    .sel_i     (sel),
    .cfg_i     (cfg),
    .arith_i   (arith),
    .carry_i   (cin),
    .lut_full_o(full),
    .lut_mid_o (mid),
    .lut_low_o (low),
    .carry_o   (cout)
  );

  function automatic void chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b (cfg=%h sel=%b arith=%b cin=%b)",
               req, act, exp, cfg, sel, arith, cin);
    end
  endfunction

  // reference model from the requirement text
  task automatic drive(input logic [15:0] c, input logic [3:0] s, input logic a, input logic ci);
    exp_t e;
    logic csel;
    @(posedge clk);
    cfg = c; sel = s; arith = a; cin = ci;
    e.full     = a ? c[{ci, s[2:0]}] : c[s];
    e.mid      = {c[{1'b1, s[2:0]}], c[{1'b0, s[2:0]}]};
    e.low      = {c[4 + int'(s[1:0])], c[s[1:0]]};
    csel       = a ? ci : s[3];
    e.cout     = e.low[1] ? csel : e.low[0];
    e.tag_full = a ? "R6" : (ci ? "R7" : "R1");
    e.tag_cout = e.low[1] ? "R5" : "R4";
    q.push_back(e);
  endtask

  task automatic drive_add(input logic ab, input logic bb, input logic ci, input logic x3);
    exp_t e;
    logic [1:0] tot;
    @(posedge clk);
    cfg = 16'h9068; sel = {x3, 1'b1, bb, ab}; arith = 1'b1; cin = ci;
    tot        = 2'(ab) + 2'(bb) + 2'(ci);
    e.full     = tot[0];
    e.cout     = tot[1];
    e.mid      = 'x;
    e.low      = {ab ^ bb, ab & bb};
    e.tag_full = "R8";
    e.tag_cout = "R8";
    q.push_back(e);
  endtask

  // monitor: results due in the same cycle, compared half a period later
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag_full, {1'b0, full}, {1'b0, e.full});
        if (e.tag_full != "R8") chk("R2", mid, e.mid);
        chk("R3", low, e.low);
        chk(e.tag_cout, {1'b0, cout}, {1'b0, e.cout});
      end
    end
  end

  initial begin
    sel = '0; cfg = '0; arith = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero configuration gives all-zero outputs (R1)
    drive(16'h0000, 4'h0, 1'b0, 1'b0);
    // exhaustive over inputs, modes and carry for fixed and random configs
    for (int k = 0; k < 40; k++) begin
      logic [15:0] c;
      case (k)
        0:       c = 16'hFFFF;
        1:       c = 16'h8000;
        2:       c = 16'h0001;
        3:       c = 16'hAAAA;
        4:       c = 16'h6996;
        5:       c = 16'hFF00;
        default: c = 16'($urandom);
      endcase
      for (int m = 0; m < 2; m++)
        for (int ci = 0; ci < 2; ci++)
          for (int s = 0; s < 16; s++)
            drive(c, 4'(s), 1'(m), 1'(ci));
    end
    // ripple adder, bit-serial through the cell (R8)
    for (int t = 0; t < 24; t++) begin
      logic [7:0] a, b;
      logic c;
      a = 8'($urandom);
      b = 8'($urandom);
      if (t == 0) begin a = 8'hFF; b = 8'h01; end
      c = 1'b0;
      for (int i = 0; i < 8; i++) begin
        drive_add(a[i], b[i], c, 1'($urandom));
        c = (2'(a[i]) + 2'(b[i]) + 2'(c)) > 2'd1;
      end
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule